// File: doc/BRIEF.md
# Multi-Lane Keyword Scanner with Boundary Overlap

The block searches a byte buffer for every occurrence of a small, fixed set of keywords. The buffer is loaded through a byte-wide write port. A start pulse then splits it into equal slices, one per lane, and each lane walks a classic keyword automaton over its slice. The automaton has forward edges and fallback links. When a lane reaches the end of its slice, it keeps reading for the length of the longest keyword minus one byte, so that a keyword crossing into the next slice is still found. The lanes run at the same time. Every hit is sent out as a keyword code and the absolute offset of its last byte.

A keyword found in the overlap region is reported only by the lane whose slice holds its first byte. Each occurrence therefore appears exactly once. A single registered output carries one hit per cycle, and a fixed-priority selector chooses among the lanes. A lane that holds an unsent hit waits until that hit has been sent. The last lane stops reading at the end of the buffer. When every lane has finished and every hit has been sent, `done` pulses for one cycle.

Top module: `acsc_scanner`

## Requirements
- R1: Four keywords are recognised, each with a fixed code: "AB" = 0, "ABG" = 1, "BEDE" = 2, "EF" = 3, in ASCII (A=0x41, B=0x42, D=0x44, E=0x45, F=0x46, G=0x47). `match_end` is the buffer address of the keyword's last byte.
- R2: When the automaton has no forward edge for the current byte, it follows its fallback link and tries the same byte again. On "ABEDE" at address 0, this reports code 0 ending at 1 and code 2 ending at 4.
- R3: A keyword that crosses the boundary between two slices is reported.
- R4: Every occurrence in the buffer is reported exactly once, including overlapping occurrences and occurrences inside the overlap region.
- R5: A keyword that ends on the final buffer byte is reported, and no lane reads past the buffer end.
- R6: After a scan starts, `done` goes high for exactly one cycle, after the last hit of that scan. `busy` is high from the cycle after start until `done`, and `match_valid` is high only while `busy` is high.
- R7: A `start` pulse while `busy` is high is ignored. It produces no second `done` and no repeated hits.
- R8: After reset, `busy`, `done` and `match_valid` are low.
- R9: Bytes that begin no keyword produce no hits. A buffer filled with 'X' (0x58) reports nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one buffer byte |
| wr_addr | input | ADDR_W | Buffer address of the write |
| wr_data | input | 8 | Byte to write |
| start | input | 1 | Begin a scan of the whole buffer (ignored while busy) |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse when the scan is finished |
| match_valid | output | 1 | A hit is presented this cycle |
| match_id | output | 2 | Keyword code of the hit |
| match_end | output | ADDR_W | Address of the hit's last byte |

## Verification
The bench builds the block with a 32-byte buffer and four lanes. Each slice is therefore 8 bytes and each lane reads 11 bytes, except the last lane, which is cut to 8 by the buffer end. These values put slice boundaries at 8, 16 and 24, which lets directed cases place keywords across every boundary, inside overlap regions and on the final byte. A brute-force search of each loaded buffer supplies the expected set of hits. Pseudo-random buffers drawn from the keyword alphabet exercise overlapping and back-to-back occurrences.

// File: rtl/acsc_pkg.sv
package acsc_pkg;
  localparam int STATE_W = 4;
  localparam int PID_W   = 2;
  localparam int MAX_PAT = 4;

  localparam logic [7:0] CH_A = 8'h41;
  localparam logic [7:0] CH_B = 8'h42;
  localparam logic [7:0] CH_D = 8'h44;
  localparam logic [7:0] CH_E = 8'h45;
  localparam logic [7:0] CH_F = 8'h46;
  localparam logic [7:0] CH_G = 8'h47;

  // Forward edge: {valid, next state}
  function automatic logic [STATE_W:0] ac_goto(input logic [STATE_W-1:0] s,
                                               input logic [7:0] c);
    logic [STATE_W:0] r;
    r = '0;
    case (s)
      4'd0: begin
        if (c == CH_A)      r = {1'b1, 4'd1};
        else if (c == CH_B) r = {1'b1, 4'd4};
        else if (c == CH_E) r = {1'b1, 4'd8};
      end
      4'd1: if (c == CH_B) r = {1'b1, 4'd2};
      4'd2: if (c == CH_G) r = {1'b1, 4'd3};
      4'd4: if (c == CH_E) r = {1'b1, 4'd5};
      4'd5: if (c == CH_D) r = {1'b1, 4'd6};
      4'd6: if (c == CH_E) r = {1'b1, 4'd7};
      4'd8: if (c == CH_F) r = {1'b1, 4'd9};
      default: r = '0;
    endcase
    return r;
  endfunction

  // Fallback link: longest proper suffix that is also a keyword prefix
  function automatic logic [STATE_W-1:0] ac_fail(input logic [STATE_W-1:0] s);
    case (s)
      4'd2:    return 4'd4;
      4'd5:    return 4'd8;
      4'd7:    return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic ac_final(input logic [STATE_W-1:0] s);
    return (s == 4'd2) || (s == 4'd3) || (s == 4'd7) || (s == 4'd9);
  endfunction

  function automatic logic [PID_W-1:0] ac_pid(input logic [STATE_W-1:0] s);
    case (s)
      4'd3:    return 2'd1;
      4'd7:    return 2'd2;
      4'd9:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic int ac_plen(input logic [STATE_W-1:0] s);
    case (s)
      4'd3:    return 3;
      4'd7:    return 4;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/acsc_bank.sv
module acsc_bank #(
  parameter int DATA_BYTES = 32,
  localparam int ADDR_W = $clog2(DATA_BYTES)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_q
);
  logic [7:0] mem [DATA_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/acsc_lane.sv
module acsc_lane
  import acsc_pkg::*;
#(
  parameter int DATA_BYTES = 32,
  parameter int NUM_LANES  = 4,
  parameter int LANE_IDX   = 0,
  localparam int ADDR_W = $clog2(DATA_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              go,
  input  logic              take,
  output logic              pend_v,
  output logic [PID_W-1:0]  pend_id,
  output logic [ADDR_W-1:0] pend_end,
  output logic              fin
);
  localparam int SEG      = DATA_BYTES / NUM_LANES;
  localparam int SEG_LO   = LANE_IDX * SEG;
  localparam int SEG_HI   = SEG_LO + SEG;
  localparam int RAW_END  = SEG_HI + MAX_PAT - 1;
  localparam int SCAN_END = (RAW_END > DATA_BYTES) ? DATA_BYTES : RAW_END;
  localparam logic [ADDR_W-1:0] LO_A   = ADDR_W'(SEG_LO);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(SCAN_END - 1);

  logic               run;
  logic [STATE_W-1:0] state;
  logic [ADDR_W-1:0]  pos;
  logic [ADDR_W-1:0]  addr_n;
  logic [7:0]         q;

  logic               g_ok;
  logic [STATE_W-1:0] g_nxt;
  logic               step_ok, advance, last, hit, in_seg;
  logic [STATE_W-1:0] nxt_state;

  acsc_bank #(.DATA_BYTES(DATA_BYTES)) bank_i (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (addr_n),
    .rd_q    (q)
  );

  always_comb begin
    {g_ok, g_nxt} = ac_goto(state, q);
    step_ok   = run && !pend_v;
    advance   = step_ok && (g_ok || (state == '0));
    last      = (pos == LAST_A);
    nxt_state = g_ok ? g_nxt : ((state == '0) ? '0 : ac_fail(state));
    hit       = step_ok && g_ok && ac_final(g_nxt);
    in_seg    = (int'(pos) + 1) < (SEG_HI + ac_plen(g_nxt));
    if (go)                   addr_n = LO_A;
    else if (advance && !last) addr_n = pos + 1'b1;
    else                      addr_n = pos;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      state    <= '0;
      pos      <= '0;
      pend_v   <= 1'b0;
      pend_id  <= '0;
      pend_end <= '0;
    end else begin
      if (go) begin
        run   <= 1'b1;
        state <= '0;
        pos   <= LO_A;
      end else if (step_ok) begin
        state <= nxt_state;
        if (advance) begin
          if (last) run <= 1'b0;
          else      pos <= pos + 1'b1;
        end
        if (hit && in_seg) begin
          pend_v   <= 1'b1;
          pend_id  <= ac_pid(g_nxt);
          pend_end <= pos;
        end
      end
      if (take) pend_v <= 1'b0;
    end
  end

  assign fin = !run;
endmodule

// File: rtl/acsc_arb.sv
module acsc_arb
  import acsc_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int ADDR_W    = 5
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_LANES-1:0]             pv,
  input  logic [NUM_LANES-1:0][PID_W-1:0]  pid,
  input  logic [NUM_LANES-1:0][ADDR_W-1:0] pend,
  output logic [NUM_LANES-1:0]             take,
  output logic                             match_valid,
  output logic [PID_W-1:0]                 match_id,
  output logic [ADDR_W-1:0]                match_end
);
  logic              found;
  logic [PID_W-1:0]  sel_id;
  logic [ADDR_W-1:0] sel_end;

  always_comb begin
    take    = '0;
    found   = 1'b0;
    sel_id  = '0;
    sel_end = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (pv[i] && !found) begin
        found   = 1'b1;
        take[i] = 1'b1;
        sel_id  = pid[i];
        sel_end = pend[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_valid <= 1'b0;
      match_id    <= '0;
      match_end   <= '0;
    end else begin
      match_valid <= found;
      match_id    <= sel_id;
      match_end   <= sel_end;
    end
  end
endmodule

// File: rtl/acsc_scanner.sv
module acsc_scanner
  import acsc_pkg::*;
#(
  parameter int DATA_BYTES = 32,
  parameter int NUM_LANES  = 4,
  localparam int ADDR_W = $clog2(DATA_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              match_valid,
  output logic [1:0]        match_id,
  output logic [ADDR_W-1:0] match_end
);
  logic                             go;
  logic [NUM_LANES-1:0]             pv, take, fin;
  logic [NUM_LANES-1:0][PID_W-1:0]  pid;
  logic [NUM_LANES-1:0][ADDR_W-1:0] pend;

  assign go = start && !busy;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    acsc_lane #(
      .DATA_BYTES (DATA_BYTES),
      .NUM_LANES  (NUM_LANES),
      .LANE_IDX   (g)
    ) lane_i (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .go       (go),
      .take     (take[g]),
      .pend_v   (pv[g]),
      .pend_id  (pid[g]),
      .pend_end (pend[g]),
      .fin      (fin[g])
    );
  end

  acsc_arb #(.NUM_LANES(NUM_LANES), .ADDR_W(ADDR_W)) arb_i (
    .clk         (clk),
    .rst         (rst),
    .pv          (pv),
    .pid         (pid),
    .pend        (pend),
    .take        (take),
    .match_valid (match_valid),
    .match_id    (match_id),
    .match_end   (match_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy <= 1'b1;
      end else if (busy && (&fin) && !(|pv)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/acsc_scanner_chk.sv
module acsc_scanner_chk #(
  parameter int DATA_BYTES = 32,
  localparam int ADDR_W = $clog2(DATA_BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              match_valid,
  input logic [1:0]        match_id,
  input logic [ADDR_W-1:0] match_end
);
  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_hit_in_scan_r6: assert property (@(posedge clk) disable iff (rst)
    match_valid |-> busy);

  p_done_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!match_valid && !busy));

  p_launch_r7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_restart_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> (busy || done));

  p_long_end_r1: assert property (@(posedge clk) disable iff (rst)
    (match_valid && match_id == 2'd2) |-> (match_end >= ADDR_W'(3)));
endmodule

bind acsc_scanner acsc_scanner_chk #(.DATA_BYTES(DATA_BYTES)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .match_valid (match_valid),
  .match_id    (match_id),
  .match_end   (match_end)
);

// File: tb/acsc_scanner_tb_top.sv
`timescale 1ns/1ps
module acsc_scanner_tb_top;
  localparam int DB = 32;
  localparam int NL = 4;
  localparam int AW = $clog2(DB);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic start = 1'b0;
  logic busy, done, match_valid;
  logic [1:0] match_id;
  logic [AW-1:0] match_end;

  always #2.5 clk = ~clk;

  acsc_scanner #(.DATA_BYTES(DB), .NUM_LANES(NL)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .busy(busy), .done(done), .match_valid(match_valid),
    .match_id(match_id), .match_end(match_end)
  );

  int errors = 0;
  int checks = 0;
  int done_cnt = 0;
  int exp_q[$];
  string cur_req = "R1";
  logic [7:0] tb_buf [DB];
  string pats [4] = '{"AB", "ABG", "BEDE", "EF"};
  int lfsr = 32'h1ACE5;

  // Monitor: each hit must be in the expected set (consumed once)
  always @(negedge clk) begin
    if (!rst) begin
      if (done) done_cnt++;
      if (match_valid) begin
        int key;
        int idx;
        key = int'(match_id) * 1000 + int'(match_end);
        idx = -1;
        foreach (exp_q[i]) if (idx < 0 && exp_q[i] == key) idx = i;
        checks++;
        if (idx >= 0) exp_q.delete(idx);
        else begin
          errors++;
          $display("FAIL %s/R4 unexpected hit: actual id=%0d end=%0d expected none",
                   cur_req, match_id, match_end);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic fill(input logic [7:0] c);
    for (int i = 0; i < DB; i++) tb_buf[i] = c;
  endtask

  task automatic put(input int off, input string s);
    for (int i = 0; i < s.len(); i++) tb_buf[off + i] = s[i];
  endtask

  task automatic load_and_expect();
    for (int i = 0; i < DB; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(i); wr_data = tb_buf[i];
    end
    @(negedge clk);
    wr_en = 1'b0;
    exp_q.delete();
    for (int s = 0; s < DB; s++) begin
      for (int p = 0; p < 4; p++) begin
        bit ok;
        ok = (s + pats[p].len() <= DB);
        for (int k = 0; k < pats[p].len() && ok; k++)
          if (tb_buf[s + k] != pats[p][k]) ok = 0;
        if (ok) exp_q.push_back(p * 1000 + s + pats[p].len() - 1);
      end
    end
  endtask

  task automatic scan(input string req, input bit extra_start);
    int d0;
    int t;
    cur_req = req;
    d0 = done_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (extra_start) begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b1, "R7", "busy before second start", int'(busy), 1);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (done_cnt == d0 && t < 3000) begin @(negedge clk); t++; end
    chk(done_cnt == d0 + 1, "R6", "done seen after scan", done_cnt - d0, 1);
    chk(exp_q.size() == 0, req, "expected hits still missing at done", exp_q.size(), 0);
    foreach (exp_q[i])
      $display("FAIL %s missing hit: actual none expected id=%0d end=%0d",
               req, exp_q[i] / 1000, exp_q[i] % 1000);
    exp_q.delete();
    repeat (20) @(negedge clk);
    chk(done_cnt == d0 + 1, extra_start ? "R7" : "R6", "single done per scan",
        done_cnt - d0, 1);
    chk(busy == 1'b0, "R6", "busy low after done", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog expired: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    chk(busy == 1'b0, "R8", "busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R8", "done after reset", int'(done), 0);
    chk(match_valid == 1'b0, "R8", "match_valid after reset", int'(match_valid), 0);

    // R9: nothing to find
    fill("X"); load_and_expect();
    chk(exp_q.size() == 0, "R9", "model finds none in X buffer", exp_q.size(), 0);
    scan("R9", 1'b0);

    // R2: fallback and retry of the same byte
    fill("X"); put(0, "ABEDE"); load_and_expect();
    chk(exp_q.size() == 2, "R2", "two hits expected", exp_q.size(), 2);
    scan("R2", 1'b0);

    // R3: keywords across slice boundaries 8, 16, 24
    fill("X"); put(7, "AB"); put(14, "BEDE"); put(23, "EF"); load_and_expect();
    scan("R3", 1'b0);

    // R4: overlapping hits, some inside overlap regions
    fill("X"); put(5, "ABEDEF"); put(13, "ABG"); put(20, "EFEF"); load_and_expect();
    scan("R4", 1'b0);

    // R5: hits ending on the final byte
    fill("X"); put(26, "EF"); put(28, "BEDE"); load_and_expect();
    scan("R5", 1'b0);

    // R1: every keyword code in one buffer
    fill("X"); put(0, "ABG"); put(4, "EF"); put(9, "BEDE"); put(18, "AB"); put(29, "ABG");
    load_and_expect();
    scan("R1", 1'b0);

    // R7: start while busy is ignored
    fill("X"); put(7, "AB"); put(14, "BEDE"); put(23, "EF"); load_and_expect();
    scan("R7", 1'b1);

    // R4/R1: pseudo-random buffers over the keyword alphabet
    for (int r = 0; r < 8; r++) begin
      string alpha;
      alpha = "ABEDGFX";
      for (int i = 0; i < DB; i++) begin
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hA3000000 : 0);
        tb_buf[i] = alpha[(lfsr & 32'h7FFF) % 7];
      end
      load_and_expect();
      scan("R4", 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule